// File: doc/BRIEF.md
# Virtualized Generic Timer Comparator

This block raises a level interrupt when a free-running 64-bit system counter passes a programmed compare point. One instance serves either as a physical timer or as a virtual timer. A mode input selects which. In virtual mode a hypervisor-owned 64-bit offset is subtracted from the counter before any use. This shifts the timebase that software sees for count reads, for the compare, and for reads and writes of the 32-bit down-count view.

Software reaches the timer through a simple register port. It has a 3-bit address, a write strobe, 64-bit write data and combinational read data. The port holds a control register (enable, interrupt mask, condition status), the 64-bit compare value, the signed 32-bit down-count view, a read-only virtual count and the offset register. Status and interrupt are evaluated continuously from the live counter. Any register write, the offset included, is reflected in status and interrupt from the first cycle in which the new value is held.

Top module: `vtimer_cmp`

## Requirements
- R1: Register addresses are 0 control, 1 compare value, 2 down-count view, 3 virtual count, 4 offset. Reads are combinational. Reset clears enable, mask, compare value and offset, and holds the interrupt low.
- R2: In virtual mode (mode input 1), address 3 reads the counter minus the offset, with 64-bit unsigned wraparound.
- R3: Control bit 2 reads 1 exactly when enable (bit 0) is 1 and the effective count (counter minus effective offset) is at least the compare value, compared as unsigned 64-bit numbers. With enable 0 it reads 0.
- R4: The interrupt output is high exactly when enable is 1, status is 1 and the mask (control bit 1) is 0.
- R5: Address 2 reads, zero-extended, the low 32 bits of the compare value minus the effective count.
- R6: A write to address 1 loads all 64 bits of the compare value. A write to address 2 loads the compare value with the effective count at the write edge plus write bits 31:0 sign-extended to 64 bits; write bits 63:32 are ignored.
- R7: A write to address 4 loads the offset. From the next cycle on, the virtual count, the status and the interrupt all follow the new offset.
- R8: A control write keeps only bits 0 and 1; bit 2 and the upper bits are ignored. Writes to address 3 and to addresses 5 to 7 change nothing, and addresses 5 to 7 read 0.
- R9: In physical mode (mode input 0) the effective offset is zero for count reads, the compare and the down-count view. The offset register stays readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| virt_mode_i | input | 1 | 1 selects virtual timer, 0 physical |
| sys_cnt_i | input | 64 | Free-running system counter value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Combinational read data for addr_i |
| irq_o | output | 1 | Level timer interrupt |

## Verification
Read data, status and interrupt are combinational in the live counter and the held registers, so they are due in the same cycle as the counter value that produces them. Every register write, including offset and down-count writes, shows up in the cycle after its clock edge. The bench drives inputs at the falling edge and compares read data and interrupt against its model one time unit later. It applies writes to the model only after the rising edge, so the first cycle after a write is checked against the new register values. Counter jumps near the top of the 64-bit range and offsets larger than the counter exercise wraparound in both the count and the compare.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTL  = 3'd0,
    REG_CVAL = 3'd1,
    REG_TVAL = 3'd2,
    REG_VCNT = 3'd3,
    REG_OFF  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/vtimer_regs.sv
module vtimer_regs
  import vtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  vcnt_i,
  output logic              en_q,
  output logic              mask_q,
  output logic [CNT_W-1:0]  cval_q,
  output logic [CNT_W-1:0]  off_q
);
  localparam int unsigned EXT_W = CNT_W - TV_W;

  // sign-extend the short down-count operand to full width
  function automatic logic [CNT_W-1:0] sext_tval(input logic [CNT_W-1:0] d);
    return {{EXT_W{d[TV_W-1]}}, d[TV_W-1:0]};
  endfunction

  // compare point reached after 'delta' more ticks of the effective count
  function automatic logic [CNT_W-1:0] tval_to_cval(input logic [CNT_W-1:0] vc,
                                                    input logic [CNT_W-1:0] d);
    return vc + sext_tval(d);
  endfunction

  logic wr_ctl, wr_cval, wr_tval, wr_off;
  assign wr_ctl  = wr_en_i && (addr_i == REG_CTL);
  assign wr_cval = wr_en_i && (addr_i == REG_CVAL);
  assign wr_tval = wr_en_i && (addr_i == REG_TVAL);
  assign wr_off  = wr_en_i && (addr_i == REG_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cval_q <= '0;
      off_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= wdata_i[0];
        mask_q <= wdata_i[1];
      end
      if (wr_cval)      cval_q <= wdata_i;
      else if (wr_tval) cval_q <= tval_to_cval(vcnt_i, wdata_i);
      if (wr_off)       off_q  <= wdata_i;
    end
  end

  assert_off_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> off_q == $past(wdata_i));

  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (en_q == $past(wdata_i[0])) && (mask_q == $past(wdata_i[1])));

  assert_cval_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cval || wr_tval) |=> $stable(cval_q));

  assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_off |=> $stable(off_q));
endmodule

// File: rtl/vtimer_eval.sv
module vtimer_eval #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             virt_mode_i,
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic [CNT_W-1:0] off_q,
  input  logic [CNT_W-1:0] cval_q,
  input  logic             en_q,
  input  logic             mask_q,
  output logic [CNT_W-1:0] vcnt_o,
  output logic             status_o,
  output logic             irq_o
);
  // offset seen by the timebase: only the virtual instance is shifted
  function automatic logic [CNT_W-1:0] eff_offset(input logic virt,
                                                  input logic [CNT_W-1:0] off);
    return virt ? off : '0;
  endfunction

  // unsigned, wrapping difference between counter and offset
  function automatic logic [CNT_W-1:0] shifted_count(input logic [CNT_W-1:0] cnt,
                                                     input logic [CNT_W-1:0] off);
    return cnt - off;
  endfunction

  logic [CNT_W-1:0] eff_off;
  logic             reached;

  assign eff_off  = eff_offset(virt_mode_i, off_q);
  assign vcnt_o   = shifted_count(sys_cnt_i, eff_off);
  assign reached  = (vcnt_o >= cval_q);
  assign status_o = en_q & reached;
  assign irq_o    = status_o & ~mask_q;

  assert_status_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o |-> en_q);

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o && !mask_q));

  assert_phys_no_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_mode_i |-> (vcnt_o == sys_cnt_i));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
endmodule

// File: rtl/vtimer_rdmux.sv
module vtimer_rdmux
  import vtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_q,
  input  logic              mask_q,
  input  logic              status_i,
  input  logic [CNT_W-1:0]  cval_q,
  input  logic [CNT_W-1:0]  off_q,
  input  logic [CNT_W-1:0]  vcnt_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = CNT_W - TV_W;
  localparam int unsigned CTL_PAD = CNT_W - 3;

  // remaining ticks to the compare point, truncated to the short view
  function automatic logic [CNT_W-1:0] tval_view(input logic [CNT_W-1:0] cv,
                                                 input logic [CNT_W-1:0] vc);
    logic [CNT_W-1:0] diff;
    diff = cv - vc;
    return {{PAD_W{1'b0}}, diff[TV_W-1:0]};
  endfunction

  always_comb begin
    unique case (addr_i)
      REG_CTL:  rdata_o = {{CTL_PAD{1'b0}}, status_i, mask_q, en_q};
      REG_CVAL: rdata_o = cval_q;
      REG_TVAL: rdata_o = tval_view(cval_q, vcnt_i);
      REG_VCNT: rdata_o = vcnt_i;
      REG_OFF:  rdata_o = off_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vtimer_cmp.sv
module vtimer_cmp
  import vtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              virt_mode_i,
  input  logic [CNT_W-1:0]  sys_cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic             en_q, mask_q, status;
  logic [CNT_W-1:0] cval_q, off_q, vcnt;

  vtimer_regs #(.CNT_W(CNT_W), .TV_W(TV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .vcnt_i  (vcnt),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .cval_q  (cval_q),
    .off_q   (off_q)
  );

  vtimer_eval #(.CNT_W(CNT_W)) u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .virt_mode_i (virt_mode_i),
    .sys_cnt_i   (sys_cnt_i),
    .off_q       (off_q),
    .cval_q      (cval_q),
    .en_q        (en_q),
    .mask_q      (mask_q),
    .vcnt_o      (vcnt),
    .status_o    (status),
    .irq_o       (irq_o)
  );

  vtimer_rdmux #(.CNT_W(CNT_W), .TV_W(TV_W)) u_rdmux (
    .addr_i   (addr_i),
    .en_q     (en_q),
    .mask_q   (mask_q),
    .status_i (status),
    .cval_q   (cval_q),
    .off_q    (off_q),
    .vcnt_i   (vcnt),
    .rdata_o  (rdata_o)
  );

  assert_status_tracks_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !mask_q) |-> irq_o);
endmodule

// File: tb/tb_vtimer_cmp.sv
module tb_vtimer_cmp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        virt = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [63:0] wdata = '0;
  logic [63:0] cnt = '0;
  logic [63:0] rdata;
  logic        irq;

  vtimer_cmp dut (
    .clk(clk), .rst_n(rst_n), .virt_mode_i(virt), .sys_cnt_i(cnt),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic        m_en = 1'b0, m_mask = 1'b0;
  logic [63:0] m_cval = '0, m_off = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [63:0] m_vc();
    logic [63:0] o;
    o = virt ? m_off : 64'd0;
    return cnt - o;
  endfunction

  function automatic logic m_st();
    return m_en && (m_vc() >= m_cval);
  endfunction

  function automatic logic [63:0] m_read(input logic [2:0] a);
    logic [63:0] r;
    r = '0;
    if (a == 3'd0) begin r[0] = m_en; r[1] = m_mask; r[2] = m_st(); end
    else if (a == 3'd1) r = m_cval;
    else if (a == 3'd2) r[31:0] = m_cval[31:0] - m_vc();
    else if (a == 3'd3) r = m_vc();
    else if (a == 3'd4) r = m_off;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check, then apply write to model after rising edge
  task automatic step(input bit w, input logic [2:0] a, input logic [63:0] d, input string tag);
    logic [63:0] tv;
    @(negedge clk);
    cnt = cnt + 64'd1;
    we = w; addr = a; wdata = d;
    #1;
    chk(tag, rdata, m_read(a));
    chk({tag, " irq R4"}, {63'd0, irq}, {63'd0, m_st() && !m_mask && rst_n});
    @(posedge clk);
    if (!rst_n) begin
      m_en = 0; m_mask = 0; m_cval = '0; m_off = '0;
    end else if (w) begin
      if (a == 3'd0) begin m_en = d[0]; m_mask = d[1]; end
      else if (a == 3'd1) m_cval = d;
      else if (a == 3'd2) begin
        tv = {{32{d[31]}}, d[31:0]};
        m_cval = m_vc() + tv;
      end
      else if (a == 3'd4) m_off = d;
    end
  endtask

  task automatic jump(input logic [63:0] v, input logic mode);
    @(negedge clk);
    we = 0; cnt = v; virt = mode;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with writes attempted during reset
    step(1, 3'd4, 64'h55, "R1 offset in reset");
    step(0, 3'd0, 0, "R1 ctl reset");
    step(0, 3'd1, 0, "R1 cval reset");
    step(0, 3'd4, 0, "R1 offset reset");
    chk("R1 irq low in reset", {63'd0, irq}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    jump(64'd1000, 1'b1);

    // R7/R2: offset shifts the virtual count
    step(1, 3'd4, 64'd100, "R7 offset write");
    step(0, 3'd3, 0, "R2 vcount");
    step(0, 3'd4, 0, "R7 offset readback");

    // R6/R3: compare a few ticks ahead, then enable and watch status rise
    step(1, 3'd1, cnt - 64'd95, "R6 cval write");
    step(1, 3'd0, 64'd1, "R3 enable");
    for (int i = 0; i < 8; i++) step(0, 3'd0, 0, "R3 status rise");
    for (int i = 0; i < 3; i++) step(0, 3'd2, 0, "R5 tval after expiry");

    // R4: mask gates the interrupt only
    step(1, 3'd0, 64'd3, "R4 mask set");
    step(0, 3'd0, 0, "R4 masked");
    step(1, 3'd0, 64'd1, "R4 unmask");
    step(0, 3'd0, 0, "R4 unmasked");

    // R6: down-count writes, negative and positive, upper bits ignored
    step(1, 3'd2, 64'h0000_0000_FFFF_FFFD, "R6 tval neg write");
    step(0, 3'd1, 0, "R6 cval from neg tval");
    step(0, 3'd0, 0, "R3 status after neg tval");
    step(1, 3'd2, 64'hDEAD_BEEF_0000_000A, "R6 tval pos write");
    step(0, 3'd1, 0, "R6 cval from pos tval");
    for (int i = 0; i < 12; i++) begin
      step(0, 3'd2, 0, "R5 tval countdown");
      step(0, 3'd0, 0, "R3 status countdown");
    end

    // R7: offset beyond the counter wraps the virtual count, status updates next cycle
    step(1, 3'd1, 64'h8000_0000_0000_0000, "R6 cval high");
    step(0, 3'd0, 0, "R3 status low");
    step(1, 3'd4, cnt + 64'd10, "R7 offset wrap write");
    step(0, 3'd0, 0, "R7 status after offset");
    step(0, 3'd3, 0, "R2 wrapped vcount");
    step(1, 3'd4, 64'd0, "R7 offset clear");
    step(0, 3'd0, 0, "R7 status after clear");

    // R8: ignored control bits and ignored addresses
    step(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFC, "R8 ctl upper bits");
    step(0, 3'd0, 0, "R8 ctl readback");
    step(1, 3'd3, 64'd123, "R8 vcount write");
    step(1, 3'd5, 64'd7, "R8 addr5 write");
    step(1, 3'd6, 64'd7, "R8 addr6 write");
    step(1, 3'd7, 64'd7, "R8 addr7 write");
    for (int a = 0; a < 8; a++) step(0, 3'(a), 0, "R8 readback");

    // R3: counter wrapping past the top of its range
    jump(64'hFFFF_FFFF_FFFF_FFF0, 1'b1);
    step(1, 3'd1, 64'hFFFF_FFFF_FFFF_FFF8, "R6 cval near top");
    step(1, 3'd0, 64'd1, "R3 enable near top");
    for (int i = 0; i < 20; i++) step(0, 3'd0, 0, "R3 status across wrap");

    // R9: physical mode ignores the offset
    jump(64'd5000, 1'b0);
    step(1, 3'd4, 64'd1_000_000, "R9 offset write phys");
    step(1, 3'd1, 64'd5004, "R9 cval phys");
    step(0, 3'd3, 0, "R9 count phys");
    step(0, 3'd4, 0, "R9 offset readable");
    for (int i = 0; i < 6; i++) begin
      step(0, 3'd0, 0, "R9 status phys");
      step(0, 3'd2, 0, "R9 tval phys");
    end
    step(1, 3'd2, 64'd20, "R9 tval write phys");
    step(0, 3'd1, 0, "R9 cval from tval phys");
    jump(cnt, 1'b1);
    step(0, 3'd3, 0, "R2 vcount back in virtual");
    step(0, 3'd0, 0, "R3 status back in virtual");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule